// File: doc/BRIEF.md
# LIN Transceiver Mode Controller

This block is the digital supervisor of a LIN physical-layer transceiver that carries its own supply regulator. It tracks four operating modes (Off, Standby, Normal, Sleep) and turns a few sensor flags and two pins into the enables for the regulator, the transmitter and the receiver. The sensor flags are battery power-on and power-off, overtemperature activate and below-release, and VCC undervoltage. The two pins are the enable input and the transmit data input. The block also drives the wake indication on the receive pin and an active-low system reset. A separate detector supplies a wake-up event. Analog comparators and the regulator itself are outside the block.

Normal mode is left through a timed window. After the enable input falls, the transmitter is blocked at once. A cycle counter opens a window a minimum number of cycles after the falling edge. The transmit data level at the opening of the window selects Standby (high) or Sleep (low). The mode changes when the window closes. If a wake-up event arrives at the same moment as a decision for Sleep, the block goes to Standby and keeps the reset released. The reset is filtered against short undervoltage glitches and stays low for a set time after the regulator becomes good. All times are clock-cycle parameters.

Top module: `lin_mode_ctrl`

## Requirements
- R1: From any mode, a high bat_off_i or ot_act_i moves the block to Off at the next clock edge. In Off, reg_en_o, tx_en_o, rx_en_o and rst_no are all low.
- R2: Off is left for Standby only at an edge where bat_on_i and ot_rel_i are both high and neither force-off flag is set. With ot_rel_i low and ot_act_i low (the hysteresis band), the block stays in Off.
- R3: Standby moves to Normal at an edge where en_i is high and rst_no is high. With rst_no low, the block remains in Standby. Sleep moves to Normal at any edge where en_i is high.
- R4: rst_no is low whenever the regulator is off. It rises RST_CYC clock edges after the edge that turned reg_en_o on, provided no undervoltage fault is present.
- R5: rst_no falls after vcc_uv_i has been high for UV_DET_CYC consecutive edges. A shorter pulse has no effect. Once vcc_uv_i clears, rst_no rises again RST_CYC+1 edges later.
- R6: tx_en_o is low in the same cycle that en_i or rst_no is low.
- R7: Number the first edge that samples en_i low in Normal as edge 1. The txd_i level at edge MSEL_MIN+1 is the choice, and later txd_i changes are ignored. At edge MSEL_MAX+1 the block enters Standby if the choice was high and Sleep if it was low. If en_i returns high before that edge, the block stays in Normal.
- R8: If rst_no is low during the cycle before the deciding edge, the block stays in Normal.
- R9: If wake_i is high at the deciding edge and the choice was low, the block enters Standby instead of Sleep. rst_no stays high and wake_ind_o rises.
- R10: In Sleep, reg_en_o and rst_no are low. In Standby, reg_en_o is high and tx_en_o and rx_en_o are low. A wake_i at an edge in Sleep with en_i low moves the block to Standby. wake_ind_o is high in Standby after a wake-up and clears when Standby is left.
- R11: After Normal is entered, tx_en_o stays low until an edge in Normal has sampled txd_i high. It rises right after that edge.
- R12: mode_o reads 0 for Off, 1 for Standby, 2 for Normal and 3 for Sleep. rx_en_o is high exactly in Normal.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| bat_on_i | input | 1 | Battery above power-on level |
| bat_off_i | input | 1 | Battery below power-off level |
| ot_act_i | input | 1 | Die temperature above activate level |
| ot_rel_i | input | 1 | Die temperature below release level |
| vcc_uv_i | input | 1 | Regulator output undervoltage |
| en_i | input | 1 | Enable pin |
| txd_i | input | 1 | Transmit data pin, high is recessive |
| wake_i | input | 1 | Wake-up event from the bus detector |
| reg_en_o | output | 1 | Regulator enable |
| tx_en_o | output | 1 | Transmitter enable |
| rx_en_o | output | 1 | Receiver enable |
| wake_ind_o | output | 1 | Drive receive pin low to flag a wake-up |
| rst_no | output | 1 | System reset, active low |
| mode_o | output | 2 | Current mode code |

## Verification
The bench builds the controller with UV_DET_CYC=3, RST_CYC=5, MSEL_MIN=2 and MSEL_MAX=6. These values make every edge count short enough to check cycle by cycle. They cover a glitch that ends one edge before the undervoltage filter trips, a transmit data change that falls between the sample edge and the closing edge, and a wake-up placed exactly on the deciding edge. The spread between MSEL_MIN and MSEL_MAX also leaves room for an undervoltage fault to trip inside the window, so the decision can be refused.

// File: rtl/lin_mode_pkg.sv
`timescale 1ns/1ps
package lin_mode_pkg;
  typedef enum logic [1:0] {
    MODE_OFF   = 2'd0,
    MODE_STBY  = 2'd1,
    MODE_NORM  = 2'd2,
    MODE_SLEEP = 2'd3
  } lin_mode_e;
endpackage

// File: rtl/lin_rst_gen.sv
`timescale 1ns/1ps
// Undervoltage filter and reset-release timer.
module lin_rst_gen #(
  parameter int UV_DET_CYC = 2500,
  parameter int RST_CYC    = 250000
) (
  input  logic clk_i,
  input  logic arst_ni,
  input  logic reg_on_i,
  input  logic vcc_uv_i,
  output logic rst_no
);
  localparam int UVW = $clog2(UV_DET_CYC + 1);
  localparam int RLW = $clog2(RST_CYC + 1);
  localparam logic [UVW-1:0] UV_LIM  = UVW'(UV_DET_CYC);
  localparam logic [RLW-1:0] REL_LIM = RLW'(RST_CYC);

  logic [UVW-1:0] uv_cnt_q, uv_cnt_d;
  logic           uv_cnt_en;
  logic [RLW-1:0] rel_cnt_q, rel_cnt_d;
  logic           rel_cnt_en;
  logic           uv_fault;
  logic           rel_clr;

  // persistence counter: saturates at the detection limit
  always_comb begin
    if (!vcc_uv_i) begin
      uv_cnt_d  = '0;
      uv_cnt_en = (uv_cnt_q != '0);
    end else begin
      uv_cnt_d  = uv_cnt_q + 1'b1;
      uv_cnt_en = (uv_cnt_q != UV_LIM);
    end
  end

  always_ff @(posedge clk_i or negedge arst_ni) begin
    if (!arst_ni)       uv_cnt_q <= '0;
    else if (uv_cnt_en) uv_cnt_q <= uv_cnt_d;
  end

  assign uv_fault = (uv_cnt_q == UV_LIM);
  assign rel_clr  = !reg_on_i || uv_fault;

  // release timer: restarts whenever the supply is not good
  always_comb begin
    if (rel_clr) begin
      rel_cnt_d  = '0;
      rel_cnt_en = (rel_cnt_q != '0);
    end else begin
      rel_cnt_d  = rel_cnt_q + 1'b1;
      rel_cnt_en = (rel_cnt_q != REL_LIM);
    end
  end

  always_ff @(posedge clk_i or negedge arst_ni) begin
    if (!arst_ni)        rel_cnt_q <= '0;
    else if (rel_cnt_en) rel_cnt_q <= rel_cnt_d;
  end

  assign rst_no = reg_on_i && !uv_fault && (rel_cnt_q == REL_LIM);
endmodule

// File: rtl/lin_msel_win.sv
`timescale 1ns/1ps
// Timed window after the enable falls in Normal mode.
module lin_msel_win #(
  parameter int MSEL_MIN = 1500,
  parameter int MSEL_MAX = 3750
) (
  input  logic clk_i,
  input  logic arst_ni,
  input  logic in_norm_i,
  input  logic en_i,
  input  logic txd_i,
  output logic decide_o,
  output logic txd_sel_o
);
  localparam int CW = $clog2(MSEL_MAX + 2);
  localparam logic [CW-1:0] MAX_V  = CW'(MSEL_MAX);
  localparam logic [CW-1:0] PARK_V = CW'(MSEL_MAX + 1);

  logic          en_d_q;
  logic          en_fall;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  always_ff @(posedge clk_i or negedge arst_ni) begin
    if (!arst_ni) en_d_q <= 1'b0;
    else          en_d_q <= en_i;
  end

  assign en_fall = in_norm_i && en_d_q && !en_i;

  // 0 idle, 1..MAX counting, PARK after the closing cycle
  always_comb begin
    if (!in_norm_i || en_i)                  cnt_d = '0;
    else if (en_fall)                        cnt_d = CW'(1);
    else if (cnt_q != '0 && cnt_q != PARK_V) cnt_d = cnt_q + 1'b1;
    else                                     cnt_d = cnt_q;
    cnt_en = (cnt_d != cnt_q);
  end

  always_ff @(posedge clk_i or negedge arst_ni) begin
    if (!arst_ni)    cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign decide_o = in_norm_i && !en_i && (cnt_q == MAX_V);

  generate
    if (MSEL_MIN == MSEL_MAX) begin : gen_same
      // opening and closing coincide: the live level decides
      assign txd_sel_o = txd_i;
    end else begin : gen_split
      localparam logic [CW-1:0] MIN_V = CW'(MSEL_MIN);
      logic smp_q;
      logic smp_en;
      assign smp_en = in_norm_i && !en_i && (cnt_q == MIN_V);
      always_ff @(posedge clk_i or negedge arst_ni) begin
        if (!arst_ni)    smp_q <= 1'b1;
        else if (smp_en) smp_q <= txd_i;
      end
      assign txd_sel_o = smp_q;
    end
  endgenerate
endmodule

// File: rtl/lin_tx_gate.sv
`timescale 1ns/1ps
// Transmitter enable: needs a recessive level seen since entering Normal.
module lin_tx_gate (
  input  logic clk_i,
  input  logic arst_ni,
  input  logic in_norm_i,
  input  logic en_i,
  input  logic rst_ni,
  input  logic txd_i,
  output logic tx_en_o
);
  logic rec_q, rec_d, rec_en;

  always_comb begin
    rec_d  = in_norm_i && (rec_q || txd_i);
    rec_en = (rec_d != rec_q);
  end

  always_ff @(posedge clk_i or negedge arst_ni) begin
    if (!arst_ni)    rec_q <= 1'b0;
    else if (rec_en) rec_q <= rec_d;
  end

  assign tx_en_o = in_norm_i && en_i && rst_ni && rec_q;
endmodule

// File: rtl/lin_mode_fsm.sv
`timescale 1ns/1ps
module lin_mode_fsm
  import lin_mode_pkg::*;
(
  input  logic      clk_i,
  input  logic      arst_ni,
  input  logic      bat_on_i,
  input  logic      bat_off_i,
  input  logic      ot_act_i,
  input  logic      ot_rel_i,
  input  logic      en_i,
  input  logic      rst_ni,
  input  logic      wake_i,
  input  logic      decide_i,
  input  logic      txd_sel_i,
  output lin_mode_e mode_o,
  output logic      wake_flag_o
);
  lin_mode_e mode_q, mode_d;
  logic      wk_q, wk_d;
  logic      upd;

  always_comb begin
    mode_d = mode_q;
    wk_d   = wk_q;
    if (bat_off_i || ot_act_i) begin
      mode_d = MODE_OFF;
      wk_d   = 1'b0;
    end else begin
      case (mode_q)
        MODE_OFF: begin
          if (bat_on_i && ot_rel_i) begin
            mode_d = MODE_STBY;
            wk_d   = 1'b0;
          end
        end
        MODE_STBY: begin
          if (en_i && rst_ni) begin
            mode_d = MODE_NORM;
            wk_d   = 1'b0;
          end else if (wake_i) begin
            wk_d = 1'b1;
          end
        end
        MODE_NORM: begin
          if (decide_i && rst_ni) begin
            if (txd_sel_i || wake_i) begin
              mode_d = MODE_STBY;
              wk_d   = wake_i;
            end else begin
              mode_d = MODE_SLEEP;
            end
          end
        end
        MODE_SLEEP: begin
          if (en_i) begin
            mode_d = MODE_NORM;
          end else if (wake_i) begin
            mode_d = MODE_STBY;
            wk_d   = 1'b1;
          end
        end
        default: begin
          mode_d = MODE_OFF;
          wk_d   = 1'b0;
        end
      endcase
    end
    upd = (mode_d != mode_q) || (wk_d != wk_q);
  end

  always_ff @(posedge clk_i or negedge arst_ni) begin
    if (!arst_ni) begin
      mode_q <= MODE_OFF;
      wk_q   <= 1'b0;
    end else if (upd) begin
      mode_q <= mode_d;
      wk_q   <= wk_d;
    end
  end

  assign mode_o      = mode_q;
  assign wake_flag_o = wk_q;
endmodule

// File: rtl/lin_mode_ctrl.sv
`timescale 1ns/1ps
module lin_mode_ctrl
  import lin_mode_pkg::*;
#(
  parameter int UV_DET_CYC = 2500,
  parameter int RST_CYC    = 250000,
  parameter int MSEL_MIN   = 1500,
  parameter int MSEL_MAX   = 3750
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       bat_on_i,
  input  logic       bat_off_i,
  input  logic       ot_act_i,
  input  logic       ot_rel_i,
  input  logic       vcc_uv_i,
  input  logic       en_i,
  input  logic       txd_i,
  input  logic       wake_i,
  output logic       reg_en_o,
  output logic       tx_en_o,
  output logic       rx_en_o,
  output logic       wake_ind_o,
  output logic       rst_no,
  output logic [1:0] mode_o
);
  logic [1:0] arst_sync_q;
  logic       arst_n;
  lin_mode_e  mode;
  logic       in_norm;
  logic       reg_on;
  logic       sys_rst_n;
  logic       decide;
  logic       txd_sel;
  logic       wake_flag;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) arst_sync_q <= 2'b00;
    else         arst_sync_q <= {arst_sync_q[0], 1'b1};
  end
  assign arst_n = arst_sync_q[1];

  assign in_norm = (mode == MODE_NORM);
  assign reg_on  = (mode == MODE_STBY) || (mode == MODE_NORM);

  lin_mode_fsm u_fsm (
    .clk_i       (clk_i),
    .arst_ni     (arst_n),
    .bat_on_i    (bat_on_i),
    .bat_off_i   (bat_off_i),
    .ot_act_i    (ot_act_i),
    .ot_rel_i    (ot_rel_i),
    .en_i        (en_i),
    .rst_ni      (sys_rst_n),
    .wake_i      (wake_i),
    .decide_i    (decide),
    .txd_sel_i   (txd_sel),
    .mode_o      (mode),
    .wake_flag_o (wake_flag)
  );

  lin_rst_gen #(
    .UV_DET_CYC (UV_DET_CYC),
    .RST_CYC    (RST_CYC)
  ) u_rst (
    .clk_i    (clk_i),
    .arst_ni  (arst_n),
    .reg_on_i (reg_on),
    .vcc_uv_i (vcc_uv_i),
    .rst_no   (sys_rst_n)
  );

  lin_msel_win #(
    .MSEL_MIN (MSEL_MIN),
    .MSEL_MAX (MSEL_MAX)
  ) u_msel (
    .clk_i     (clk_i),
    .arst_ni   (arst_n),
    .in_norm_i (in_norm),
    .en_i      (en_i),
    .txd_i     (txd_i),
    .decide_o  (decide),
    .txd_sel_o (txd_sel)
  );

  lin_tx_gate u_txg (
    .clk_i     (clk_i),
    .arst_ni   (arst_n),
    .in_norm_i (in_norm),
    .en_i      (en_i),
    .rst_ni    (sys_rst_n),
    .txd_i     (txd_i),
    .tx_en_o   (tx_en_o)
  );

  assign reg_en_o   = reg_on;
  assign rx_en_o    = in_norm;
  assign wake_ind_o = (mode == MODE_STBY) && wake_flag;
  assign rst_no     = sys_rst_n;
  assign mode_o     = mode;
endmodule

// File: rtl/lin_mode_chk.sv
`timescale 1ns/1ps
module lin_mode_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       bat_on_i,
  input logic       bat_off_i,
  input logic       ot_act_i,
  input logic       ot_rel_i,
  input logic       en_i,
  input logic       wake_i,
  input logic       reg_en_o,
  input logic       tx_en_o,
  input logic       rx_en_o,
  input logic       wake_ind_o,
  input logic       rst_no,
  input logic [1:0] mode_o
);
  AST_OFF_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_o == 2'd0) |-> (!reg_en_o && !tx_en_o && !rx_en_o && !rst_no)); // R1

  AST_FORCE_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bat_off_i || ot_act_i) |=> (mode_o == 2'd0)); // R1

  AST_OFF_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((mode_o == 2'd0) && !(bat_on_i && ot_rel_i)) |=> (mode_o == 2'd0)); // R2

  AST_SLEEP_EN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((mode_o == 2'd3) && en_i && !bat_off_i && !ot_act_i) |=> (mode_o == 2'd2)); // R3

  AST_TX_NEEDS_EN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_en_o |-> (en_i && rst_no)); // R6

  AST_NORM_HOLD_NO_RST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((mode_o == 2'd2) && !rst_no && !bat_off_i && !ot_act_i) |=> (mode_o == 2'd2)); // R8

  AST_COLLIDE_NO_SLEEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((mode_o == 2'd2) && wake_i && !bat_off_i && !ot_act_i) |=> (mode_o != 2'd3)); // R9

  AST_SLEEP_DARK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_o == 2'd3) |-> (!reg_en_o && !rst_no && !tx_en_o)); // R10

  AST_STBY_LIN_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_o == 2'd1) |-> (reg_en_o && !tx_en_o && !rx_en_o)); // R10

  AST_WAKE_IND_STBY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wake_ind_o |-> (mode_o == 2'd1)); // R10

  AST_TX_LATE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_o != 2'd2) |=> !tx_en_o); // R11
endmodule

bind lin_mode_ctrl lin_mode_chk u_mode_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .bat_on_i   (bat_on_i),
  .bat_off_i  (bat_off_i),
  .ot_act_i   (ot_act_i),
  .ot_rel_i   (ot_rel_i),
  .en_i       (en_i),
  .wake_i     (wake_i),
  .reg_en_o   (reg_en_o),
  .tx_en_o    (tx_en_o),
  .rx_en_o    (rx_en_o),
  .wake_ind_o (wake_ind_o),
  .rst_no     (rst_no),
  .mode_o     (mode_o)
);

// File: tb/lin_mode_ctrl_tb_top.sv
`timescale 1ns/1ps
module lin_mode_ctrl_tb_top;
  localparam int UVC  = 3;
  localparam int RSTC = 5;
  localparam int MMIN = 2;
  localparam int MMAX = 6;

  logic clk = 1'b0;
  logic rst_ni, bat_on, bat_off, ot_act, ot_rel, vcc_uv, en, txd, wake;
  logic reg_en, tx_en, rx_en, wake_ind, sys_rst_n;
  logic [1:0] mode;
  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  lin_mode_ctrl #(
    .UV_DET_CYC (UVC),
    .RST_CYC    (RSTC),
    .MSEL_MIN   (MMIN),
    .MSEL_MAX   (MMAX)
  ) dut_i (
    .clk_i      (clk),
    .rst_ni     (rst_ni),
    .bat_on_i   (bat_on),
    .bat_off_i  (bat_off),
    .ot_act_i   (ot_act),
    .ot_rel_i   (ot_rel),
    .vcc_uv_i   (vcc_uv),
    .en_i       (en),
    .txd_i      (txd),
    .wake_i     (wake),
    .reg_en_o   (reg_en),
    .tx_en_o    (tx_en),
    .rx_en_o    (rx_en),
    .wake_ind_o (wake_ind),
    .rst_no     (sys_rst_n),
    .mode_o     (mode)
  );

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic t_reset;
    chk("R1 reset mode", int'(mode), 0);
    chk("R1 reset regulator", int'(reg_en), 0);
    chk("R1 reset rst", int'(sys_rst_n), 0);
  endtask

  task automatic t_power_up;
    bat_on = 1'b1; ot_rel = 1'b0;
    step(3);
    chk("R2 hold off in band", int'(mode), 0);
    ot_rel = 1'b1;
    step(1);
    chk("R2 off to standby", int'(mode), 1);
    chk("R10 standby regulator", int'(reg_en), 1);
    chk("R12 standby rx", int'(rx_en), 0);
    step(RSTC - 1);
    chk("R4 reset still low", int'(sys_rst_n), 0);
    step(1);
    chk("R4 reset released", int'(sys_rst_n), 1);
  endtask

  task automatic t_to_normal;
    txd = 1'b0; en = 1'b1;
    step(1);
    chk("R3 standby to normal", int'(mode), 2);
    chk("R12 normal rx", int'(rx_en), 1);
    chk("R11 tx off on entry", int'(tx_en), 0);
    step(2);
    chk("R11 tx off while dominant", int'(tx_en), 0);
    txd = 1'b1;
    step(1);
    chk("R11 tx on after recessive", int'(tx_en), 1);
  endtask

  task automatic t_uv;
    vcc_uv = 1'b1;
    step(UVC - 1);
    vcc_uv = 1'b0;
    step(1);
    chk("R5 short glitch ignored", int'(sys_rst_n), 1);
    vcc_uv = 1'b1;
    step(UVC - 1);
    chk("R5 before filter", int'(sys_rst_n), 1);
    step(1);
    chk("R5 reset on uv", int'(sys_rst_n), 0);
    chk("R6 tx off with reset", int'(tx_en), 0);
    vcc_uv = 1'b0;
    step(RSTC);
    chk("R5 still in reset", int'(sys_rst_n), 0);
    step(1);
    chk("R5 reset back", int'(sys_rst_n), 1);
    chk("R5 mode kept", int'(mode), 2);
  endtask

  task automatic t_sleep;
    chk("R11 tx on before exit", int'(tx_en), 1);
    en = 1'b0; txd = 1'b0;
    #1;
    chk("R6 tx blocked at once", int'(tx_en), 0);
    step(MMAX);
    chk("R7 normal until close", int'(mode), 2);
    step(1);
    chk("R7 enter sleep", int'(mode), 3);
    chk("R10 sleep regulator", int'(reg_en), 0);
    chk("R10 sleep reset", int'(sys_rst_n), 0);
  endtask

  task automatic t_wake_sleep;
    wake = 1'b1;
    step(1);
    wake = 1'b0;
    chk("R10 wake to standby", int'(mode), 1);
    chk("R10 wake indication", int'(wake_ind), 1);
    step(RSTC);
    chk("R10 indication held", int'(wake_ind), 1);
    chk("R4 reset after wake", int'(sys_rst_n), 1);
    txd = 1'b1; en = 1'b1;
    step(1);
    chk("R3 normal again", int'(mode), 2);
    chk("R10 indication cleared", int'(wake_ind), 0);
    step(1);
  endtask

  task automatic t_stby_select;
    en = 1'b0;
    step(MMIN + 1);
    txd = 1'b0;
    step(MMAX - MMIN - 1);
    chk("R7 normal before close", int'(mode), 2);
    step(1);
    chk("R7 late txd ignored, standby", int'(mode), 1);
    chk("R7 reset kept in standby", int'(sys_rst_n), 1);
    chk("R10 no wake flag", int'(wake_ind), 0);
  endtask

  task automatic t_abort;
    en = 1'b1; txd = 1'b1;
    step(2);
    en = 1'b0; txd = 1'b0;
    step(4);
    en = 1'b1;
    step(4);
    chk("R7 abort stays normal", int'(mode), 2);
    txd = 1'b1;
    step(1);
  endtask

  task automatic t_collide;
    en = 1'b0; txd = 1'b0;
    step(MMAX);
    wake = 1'b1;
    step(1);
    wake = 1'b0;
    chk("R9 collision to standby", int'(mode), 1);
    chk("R9 no reset", int'(sys_rst_n), 1);
    chk("R9 wake indication", int'(wake_ind), 1);
  endtask

  task automatic t_exit_needs_rst;
    en = 1'b1; txd = 1'b1;
    step(1);
    chk("R3 normal for refusal", int'(mode), 2);
    en = 1'b0; txd = 1'b0; vcc_uv = 1'b1;
    step(MMAX + 1);
    chk("R8 exit refused", int'(mode), 2);
    vcc_uv = 1'b0; en = 1'b1; txd = 1'b1;
    step(RSTC + 1);
    chk("R8 reset recovered", int'(sys_rst_n), 1);
  endtask

  task automatic t_off;
    ot_act = 1'b1;
    step(1);
    chk("R1 overtemp to off", int'(mode), 0);
    chk("R1 off regulator", int'(reg_en), 0);
    chk("R1 off tx", int'(tx_en), 0);
    chk("R1 off reset", int'(sys_rst_n), 0);
    ot_act = 1'b0; ot_rel = 1'b0;
    step(3);
    chk("R2 hysteresis holds off", int'(mode), 0);
    ot_rel = 1'b1; en = 1'b0;
    step(1);
    chk("R2 release to standby", int'(mode), 1);
    bat_off = 1'b1;
    step(1);
    chk("R1 battery to off", int'(mode), 0);
    bat_off = 1'b0;
    step(1);
    chk("R2 battery back", int'(mode), 1);
  endtask

  task automatic t_stby_rst_low;
    en = 1'b1;
    step(1);
    chk("R3 standby held in reset", int'(mode), 1);
    step(RSTC);
    chk("R3 normal after reset", int'(mode), 2);
  endtask

  task automatic t_sleep_en;
    txd = 1'b0; en = 1'b0;
    step(MMAX + 1);
    chk("R7 sleep again", int'(mode), 3);
    en = 1'b1;
    step(1);
    chk("R3 sleep to normal", int'(mode), 2);
  endtask

  initial begin
    rst_ni = 1'b0; bat_on = 1'b0; bat_off = 1'b0; ot_act = 1'b0;
    ot_rel = 1'b0; vcc_uv = 1'b0; en = 1'b0; txd = 1'b1; wake = 1'b0;
    step(2);
    t_reset();
    rst_ni = 1'b1;
    step(3);
    t_power_up();
    t_to_normal();
    t_uv();
    t_sleep();
    t_wake_sleep();
    t_stby_select();
    t_abort();
    t_collide();
    t_exit_needs_rst();
    t_off();
    t_stby_rst_low();
    t_sleep_en();
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #800000;
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule